// File: doc/BRIEF.md
# Wiper Position Register with Tap Decoder

This block holds the position of a digitally controlled potentiometer wiper as an 8-bit volatile value. It drives a one-hot vector of 256 tap-switch enables, so exactly one tap of the resistor chain connects to the wiper at any time. The value can change in four ways:

- a host can write a new position directly;
- a host can copy one of four stored data-register values into the position;
- a host can move the wiper up or down by one tap;
- after power-up, the position is loaded from the default stored value.

The surrounding control logic owns the serial protocol and the stored registers. It presents their contents on a flat bus and raises single-cycle request strobes. The block resolves competing requests by a fixed priority. The position saturates at both ends of the chain instead of wrapping around. The decoder is purely combinational from the position register, so the tap vector follows the position in the same cycle. The tap vector can only change when that one register changes.

Top module: `wiper_reg`

## Requirements
- R1: While `rst_n` is low, `pos` is 00h and `tap_sel` has only bit 0 set.
- R2: On the first rising clock edge after `rst_n` goes high, `pos` loads `dflt_val`, whatever the other request inputs are.
- R3: When `recall` is high at a rising edge, `pos` loads `dflt_val`. This has priority over every other request.
- R4: When `wr_en` is high and no recall is active, `pos` loads `wr_data`. This has priority over transfer and stepping.
- R5: When `xfer_en` is high and no recall or write is active, `pos` loads stored register k, where k is `xfer_sel`. Register k occupies bits [8k+7:8k] of `dr_bus`. A transfer has priority over stepping.
- R6: When `step_en` is high with `step_up` = 1 and no higher request is active, `pos` increases by one. At FFh it stays at FFh.
- R7: When `step_en` is high with `step_up` = 0 and no higher request is active, `pos` decreases by one. At 00h it stays at 00h.
- R8: `tap_sel` always has exactly one bit set, and that bit is at index `pos`. Bit 0 is the low-terminal end and bit 255 is the high-terminal end.
- R9: When no request is active, `pos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| recall | input | 1 | Reload the position from the default stored value |
| dflt_val | input | 8 | Default stored value (stored register 0 of bank 0) |
| wr_en | input | 1 | Direct write request |
| wr_data | input | 8 | Position for a direct write |
| xfer_en | input | 1 | Transfer request from a stored register |
| xfer_sel | input | 2 | Index of the stored register to transfer |
| dr_bus | input | 32 | Stored register contents, register k at bits [8k+7:8k] |
| step_en | input | 1 | One-tap step request |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| pos | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot tap-switch enables |

## Verification
Random cycles raise several request strobes at once, which exercises every priority order: the value loaded shows which source won. Write values are biased toward 00h, 01h, FEh and FFh, so random steps often land on the ends of the chain. Directed sequences then walk the position into both saturation points and use a distinct value in each stored register, so that a wrong transfer index gives a wrong result. Each cycle also compares the whole tap vector with a single bit at the expected index. This catches a double enable or a shifted decode.

// File: rtl/wiper_reg.sv
module wiper_reg #(
  parameter  int W    = 8,
  parameter  int NDR  = 4,
  localparam int NTAP = 1 << W,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall,
  input  logic [W-1:0]      dflt_val,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              xfer_en,
  input  logic [SELW-1:0]   xfer_sel,
  input  logic [NDR*W-1:0]  dr_bus,
  input  logic              step_en,
  input  logic              step_up,
  output logic [W-1:0]      pos,
  output logic [NTAP-1:0]   tap_sel
);

  logic         boot_q;
  logic [W-1:0] pos_q, pos_d, xfer_val;
  logic         at_top, at_bot;

  assign xfer_val = dr_bus[xfer_sel*W +: W];
  assign at_top   = &pos_q;
  assign at_bot   = ~|pos_q;

  always_comb begin
    pos_d = pos_q;
    if (boot_q || recall)   pos_d = dflt_val;
    else if (wr_en)         pos_d = wr_data;
    else if (xfer_en)       pos_d = xfer_val;
    else if (step_en) begin
      if (step_up && !at_top)       pos_d = pos_q + 1'b1;
      else if (!step_up && !at_bot) pos_d = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      pos_q  <= '0;
    end else begin
      boot_q <= 1'b0;
      pos_q  <= pos_d;
    end
  end

  assign pos = pos_q;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_sel[i] = (pos_q == W'(i));
  end

endmodule

// File: rtl/wiper_reg_chk.sv
module wiper_reg_chk #(
  parameter  int W    = 8,
  parameter  int NDR  = 4,
  localparam int NTAP = 1 << W,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boot_q,
  input logic             recall,
  input logic [W-1:0]     dflt_val,
  input logic             wr_en,
  input logic [W-1:0]     wr_data,
  input logic             xfer_en,
  input logic [SELW-1:0]  xfer_sel,
  input logic [NDR*W-1:0] dr_bus,
  input logic             step_en,
  input logic             step_up,
  input logic [W-1:0]     pos,
  input logic [NTAP-1:0]  tap_sel
);

  logic hi_req, none_req;
  assign hi_req   = boot_q || recall || wr_en || xfer_en;
  assign none_req = !hi_req && !step_en;

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (pos == '0 && tap_sel[0]));

  p_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> pos == $past(dflt_val));

  p_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> pos == $past(dflt_val));

  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && !recall && wr_en) |=> pos == $past(wr_data));

  p_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && !recall && !wr_en && xfer_en) |=> pos == $past(dr_bus[xfer_sel*W +: W]));

  p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_req && step_en && step_up && &pos) |=> &pos);

  p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_req && step_en && !step_up && pos == '0) |=> pos == '0);

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[pos]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    none_req |=> $stable(pos));

endmodule

bind wiper_reg wiper_reg_chk #(.W(W), .NDR(NDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_q(boot_q), .recall(recall),
  .dflt_val(dflt_val), .wr_en(wr_en), .wr_data(wr_data),
  .xfer_en(xfer_en), .xfer_sel(xfer_sel), .dr_bus(dr_bus),
  .step_en(step_en), .step_up(step_up), .pos(pos), .tap_sel(tap_sel)
);

// File: tb/wiper_reg_tb.sv
module wiper_reg_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         recall = 1'b0, wr_en = 1'b0, xfer_en = 1'b0, step_en = 1'b0, step_up = 1'b0;
  logic [7:0]   dflt_val = 8'h00, wr_data = 8'h00;
  logic [1:0]   xfer_sel = 2'd0;
  logic [31:0]  dr_bus = 32'h0;
  logic [7:0]   pos;
  logic [255:0] tap_sel;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] exp_pos;

  always #5 clk = ~clk;

  wiper_reg u_dut (.*);

  function automatic logic [7:0] model(input logic [7:0] cur);
    if (recall)       return dflt_val;
    if (wr_en)        return wr_data;
    if (xfer_en)      return dr_bus[xfer_sel*8 +: 8];
    if (step_en) begin
      if (step_up)    return (cur == 8'hFF) ? cur : cur + 8'd1;
      else            return (cur == 8'h00) ? cur : cur - 8'd1;
    end
    return cur;
  endfunction

  function automatic string tag_of(input logic [7:0] cur);
    if (recall)  return "R3";
    if (wr_en)   return "R4";
    if (xfer_en) return "R5";
    if (step_en) return step_up ? "R6" : "R7";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [7:0] e);
    n_chk++;
    if (pos !== e) begin
      n_fail++;
      $display("FAIL %s pos actual=%h expected=%h", tag, pos, e);
    end
    n_chk++;
    if (tap_sel !== (256'b1 << e)) begin
      n_fail++;
      $display("FAIL R8 tap_sel actual idx/count=%0d/%0d expected idx=%0d",
               $clog2(tap_sel), $countones(tap_sel), e);
    end
  endtask

  task automatic cycle();
    string t;
    t = tag_of(exp_pos);
    exp_pos = model(exp_pos);
    @(posedge clk);
    @(negedge clk);
    check(t, exp_pos);
    {recall, wr_en, xfer_en, step_en} = 4'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v; cycle();
  endtask

  task automatic do_step(input logic up);
    step_en = 1'b1; step_up = up; cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1", 8'h00);
    dflt_val = 8'h5A; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", 8'h5A);
    exp_pos = 8'h5A;
    wr_en = 1'b0;
    cycle();

    do_write(8'hFE);
    do_step(1'b1);
    do_step(1'b1);
    do_step(1'b1);
    do_write(8'h01);
    do_step(1'b0);
    do_step(1'b0);
    do_step(1'b0);

    dr_bus = 32'hC3_82_41_10;
    for (int k = 0; k < 4; k++) begin
      xfer_en = 1'b1; xfer_sel = 2'(k); cycle();
    end
    recall = 1'b1; wr_en = 1'b1; wr_data = 8'h77; xfer_en = 1'b1; step_en = 1'b1; cycle();
    wr_en = 1'b1; wr_data = 8'h33; xfer_en = 1'b1; xfer_sel = 2'd3; step_en = 1'b1; cycle();
    xfer_en = 1'b1; xfer_sel = 2'd2; step_en = 1'b1; step_up = 1'b1; cycle();

    for (int i = 0; i < 2000; i++) begin
      recall  = ($urandom % 16) == 0;
      wr_en   = ($urandom % 4) == 0;
      xfer_en = ($urandom % 5) == 0;
      step_en = ($urandom % 2) == 0;
      step_up = $urandom % 2;
      xfer_sel = 2'($urandom % 4);
      dr_bus  = $urandom;
      dflt_val = 8'($urandom);
      case ($urandom % 6)
        0: wr_data = 8'h00;
        1: wr_data = 8'h01;
        2: wr_data = 8'hFE;
        3: wr_data = 8'hFF;
        default: wr_data = 8'($urandom);
      endcase
      cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule